// File: doc/BRIEF.md
# External Bus Cycle Controller

This block turns single read and write requests from an on-chip requester into timed cycles on an external peripheral bus. The requester raises `req` with an address, a direction and write data, and holds them. The controller compares the address against a set of programmable address windows. It drives the active-low select line of the winning window and holds it for that window's programmed number of wait clocks. It then closes the cycle with a one-clock `ready` pulse. Read data is presented to the requester in that same clock.

Each window can close its cycles in one of two ways. It can close them on its own, when the wait count runs out. Or it can wait for an acknowledge from the external device. The acknowledge line passes through a synchronizer, and a global mode bit selects its active level. An acknowledge that is still active from the previous cycle is not accepted: the line must first be seen inactive. Select line 5 can be turned into a memory strobe with a programmable delay. Select line 4 can be handed over to a register-driven general-purpose pin. All settings are written through a small register write port.

Top module: `xbus_cyc_ctrl`

## Requirements
- R1: A select line is driven low only while a cycle runs for an address with base <= address <= limit in an enabled window. When windows overlap, the lowest-numbered matching window wins.
- R2: A window with its self-acknowledge bit set raises `ready` exactly W clocks after the accepting clock, where W is that window's wait count. The acknowledge input has no effect on such a cycle.
- R3: A window without self-acknowledge raises `ready` in clock max(W, a+2), where the acknowledge is driven active a clocks after the accepting clock. The +2 is the two synchronizer stages.
- R4: Mode bit 0 selects the active level of the acknowledge pin: 1 means active high, 0 means active low.
- R5: An acknowledge seen active at the end of one cycle must be seen inactive at least once before it can complete another cycle.
- R6: An address that matches no enabled window completes in the accepting clock + 0 (`ready` in the first clock). No select line goes low, and the read data is zero.
- R7: `ready` is high for exactly one clock. On a read, `rsp_rdata` equals `xb_rdata` in that clock. On a write it is zero.
- R8: After every `ready`, at least one clock follows with all window selects inactive. No two windows are ever selected in the same clock.
- R9: With mode bit 1 set, `xb_cs_n[5]` becomes a strobe for any cycle that hits a window. It goes low from clock min(D, W) of the cycle, where D is mode bits [11:8], and is released together with the cycle.
- R10: With bit 0 of general-purpose mode set, `xb_cs_n[4]` carries bit 0 of the general-purpose output register and `xb_gp_oe` carries bit 1. Otherwise `xb_gp_oe` is 1.
- R11: Register map: `cfg_addr[4:3]` = 0 selects the window base, 1 the inclusive limit, and 2 the window control (bits [3:0] wait count, bit 8 self-acknowledge, bit 9 enable). For each of these, `cfg_addr[2:0]` is the window index. `cfg_addr` = 0x18 is mode, 0x19 is general-purpose mode and 0x1A is general-purpose output. Reset clears every register, so all windows are disabled and all selects are high.
- R12: While a cycle runs, `xb_rd_n` (read) or `xb_wr_n` (write) is low, never both, and `xb_addr`/`xb_wdata` hold the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, held until `ready` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `ready` |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register index |
| cfg_wdata | input | 32 | Register write data |
| xb_addr | output | 16 | External address |
| xb_wdata | output | 16 | External write data |
| xb_rdata | input | 16 | External read data |
| xb_rd_n | output | 1 | Read strobe, active low |
| xb_wr_n | output | 1 | Write strobe, active low |
| xb_cs_n | output | 6 | Window selects, active low (bit 5 may be the strobe, bit 4 may be the GP pin) |
| xb_ack | input | 1 | External acknowledge, programmable level |
| xb_gp_oe | output | 1 | Output enable for select pin 4 |

## Verification
The hardest state to reach is an acknowledge-mode cycle that starts while the acknowledge is still held active from the cycle before. Only this case shows whether the arming rule works. The stimulus completes one acknowledged cycle and leaves the acknowledge asserted. It then issues a second acknowledged request, drops the acknowledge for one clock partway through and raises it again. The completion clock must then match the re-assertion and not the wait count. Random cycles over overlapping windows, unmapped addresses and random acknowledge delays run around this directed sequence.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACT  = 2'd1,
      ST_MISS = 2'd2
   } xb_state_e;

   localparam int CFG_AW = 5;

   // register groups selected by cfg_addr[4:3]
   localparam logic [1:0] GRP_BASE   = 2'd0;
   localparam logic [1:0] GRP_LIMIT  = 2'd1;
   localparam logic [1:0] GRP_CTRL   = 2'd2;
   localparam logic [1:0] GRP_GLOBAL = 2'd3;

   // global registers selected by cfg_addr[2:0]
   localparam logic [2:0] G_MODE   = 3'd0;
   localparam logic [2:0] G_GPMODE = 3'd1;
   localparam logic [2:0] G_GPOUT  = 3'd2;

   localparam int CTRL_SELF_BIT = 8;
   localparam int CTRL_EN_BIT   = 9;
   localparam int MODE_POL_BIT  = 0;
   localparam int MODE_STRB_BIT = 1;
   localparam int MODE_DLY_LSB  = 8;

   localparam int CS_GPIO = 4;
   localparam int CS_STRB = 5;

endpackage

// File: rtl/xbus_regs.sv
module xbus_regs
   import xbus_pkg::*;
#(
   parameter int AW  = 16,
   parameter int WSW = 4,
   parameter int NCS = 6,
   parameter int CW  = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CFG_AW-1:0]    cfg_addr,
   input  logic [CW-1:0]        cfg_wdata,
   output logic [AW-1:0]        win_base  [NCS],
   output logic [AW-1:0]        win_limit [NCS],
   output logic [WSW-1:0]       win_wait  [NCS],
   output logic [NCS-1:0]       win_self,
   output logic [NCS-1:0]       win_en,
   output logic                 ack_pol,
   output logic                 strb_mode,
   output logic [WSW-1:0]       strb_dly,
   output logic                 gp_mode,
   output logic                 gp_val,
   output logic                 gp_oe
);

   logic [1:0] grp;
   logic [2:0] idx;
   assign grp = cfg_addr[4:3];
   assign idx = cfg_addr[2:0];

   generate
      for (genvar i = 0; i < NCS; i++) begin : g_win
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_base[i]  <= '0;
               win_limit[i] <= '0;
               win_wait[i]  <= '0;
               win_self[i]  <= 1'b0;
               win_en[i]    <= 1'b0;
            end else if (cfg_we && idx == 3'(i)) begin
               case (grp)
                  GRP_BASE:  win_base[i]  <= cfg_wdata[AW-1:0];
                  GRP_LIMIT: win_limit[i] <= cfg_wdata[AW-1:0];
                  GRP_CTRL: begin
                     win_wait[i] <= cfg_wdata[WSW-1:0];
                     win_self[i] <= cfg_wdata[CTRL_SELF_BIT];
                     win_en[i]   <= cfg_wdata[CTRL_EN_BIT];
                  end
                  default: ;
               endcase
            end
         end
      end

      if (CW > AW) begin : g_sink
         logic unused_hi;
         assign unused_hi = ^cfg_wdata[CW-1:AW];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_pol   <= 1'b0;
         strb_mode <= 1'b0;
         strb_dly  <= '0;
         gp_mode   <= 1'b0;
         gp_val    <= 1'b0;
         gp_oe     <= 1'b0;
      end else if (cfg_we && grp == GRP_GLOBAL) begin
         case (idx)
            G_MODE: begin
               ack_pol   <= cfg_wdata[MODE_POL_BIT];
               strb_mode <= cfg_wdata[MODE_STRB_BIT];
               strb_dly  <= cfg_wdata[MODE_DLY_LSB +: WSW];
            end
            G_GPMODE: gp_mode <= cfg_wdata[0];
            G_GPOUT: begin
               gp_val <= cfg_wdata[0];
               gp_oe  <= cfg_wdata[1];
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/xbus_decode.sv
module xbus_decode #(
   parameter int AW  = 16,
   parameter int NCS = 6
) (
   input  logic [AW-1:0]  addr,
   input  logic [AW-1:0]  win_base  [NCS],
   input  logic [AW-1:0]  win_limit [NCS],
   input  logic [NCS-1:0] win_en,
   output logic           hit,
   output logic [NCS-1:0] sel_oh
);

   logic [NCS-1:0] match;

   generate
      for (genvar i = 0; i < NCS; i++) begin : g_cmp
         assign match[i] = win_en[i] && (addr >= win_base[i]) && (addr <= win_limit[i]);
      end
   endgenerate

   // lowest index wins: scan downward so the last write is the lowest match
   always_comb begin
      sel_oh = '0;
      for (int i = NCS - 1; i >= 0; i--) begin
         if (match[i]) begin
            sel_oh    = '0;
            sel_oh[i] = 1'b1;
         end
      end
   end

   assign hit = |match;

endmodule

// File: rtl/xbus_ack_sync.sv
module xbus_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[STAGES-2:0], d};
         end
         assign q = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int AW  = 16,
   parameter int DW  = 16,
   parameter int WSW = 4,
   parameter int NCS = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req,
   input  logic           req_we,
   input  logic [AW-1:0]  req_addr,
   input  logic [DW-1:0]  req_wdata,
   output logic           ready,
   output logic [DW-1:0]  rsp_rdata,
   input  logic           dec_hit,
   input  logic [NCS-1:0] dec_oh,
   input  logic [WSW-1:0] win_wait [NCS],
   input  logic [NCS-1:0] win_self,
   input  logic [WSW-1:0] strb_dly,
   input  logic           ack_s,
   input  logic [DW-1:0]  xb_rdata,
   output logic [NCS-1:0] cs_act_oh,
   output logic           strb_on,
   output logic [AW-1:0]  xb_addr,
   output logic [DW-1:0]  xb_wdata,
   output logic           xb_rd_n,
   output logic           xb_wr_n
);

   xb_state_e      state;
   logic [WSW-1:0] cnt;
   logic [WSW-1:0] thr;
   logic [NCS-1:0] oh_q;
   logic           self_q;
   logic           we_q;
   logic           armed;
   logic [AW-1:0]  addr_q;
   logic [DW-1:0]  wdata_q;

   logic [WSW-1:0] w_sel;
   logic           s_sel;
   logic [WSW-1:0] dly_eff;
   logic           accept;
   logic           done;
   logic           in_act;

   always_comb begin
      w_sel = '0;
      s_sel = 1'b0;
      for (int i = 0; i < NCS; i++) begin
         if (dec_oh[i]) begin
            w_sel = win_wait[i];
            s_sel = win_self[i];
         end
      end
   end

   assign dly_eff = (strb_dly > w_sel) ? w_sel : strb_dly;
   assign accept  = (state == ST_IDLE) && req;
   assign in_act  = (state == ST_ACT);
   assign done    = in_act && (cnt == '0) && (self_q || (ack_s && armed));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         thr     <= '0;
         oh_q    <= '0;
         self_q  <= 1'b0;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         case (state)
            ST_IDLE: if (accept) begin
               state   <= dec_hit ? ST_ACT : ST_MISS;
               cnt     <= w_sel;
               thr     <= w_sel - dly_eff;
               oh_q    <= dec_oh;
               self_q  <= s_sel;
               we_q    <= req_we;
               addr_q  <= req_addr;
               wdata_q <= req_wdata;
            end
            ST_ACT: begin
               if (cnt != '0) cnt <= cnt - WSW'(1);
               if (done)      state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // acknowledge arming: re-armed by any inactive sample, spent by a completion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                armed <= 1'b0;
      else if (!ack_s)           armed <= 1'b1;
      else if (done && !self_q)  armed <= 1'b0;
   end

   assign ready     = done || (state == ST_MISS);
   assign rsp_rdata = (done && !we_q) ? xb_rdata : '0;
   assign cs_act_oh = in_act ? oh_q : '0;
   assign strb_on   = in_act && (cnt <= thr);
   assign xb_addr   = addr_q;
   assign xb_wdata  = wdata_q;
   assign xb_rd_n   = !(in_act && !we_q);
   assign xb_wr_n   = !(in_act && we_q);

endmodule

// File: rtl/xbus_cyc_ctrl.sv
module xbus_cyc_ctrl
   import xbus_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 16,
   parameter int NCS         = 6,
   parameter int WSW         = 4,
   parameter int CW          = 32,
   parameter int ACK_SYNC    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_we,
   input  logic [AW-1:0]     req_addr,
   input  logic [DW-1:0]     req_wdata,
   output logic              ready,
   output logic [DW-1:0]     rsp_rdata,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CW-1:0]     cfg_wdata,
   output logic [AW-1:0]     xb_addr,
   output logic [DW-1:0]     xb_wdata,
   input  logic [DW-1:0]     xb_rdata,
   output logic              xb_rd_n,
   output logic              xb_wr_n,
   output logic [NCS-1:0]    xb_cs_n,
   input  logic              xb_ack,
   output logic              xb_gp_oe
);

   generate
      if (NCS < 6 || NCS > 8) begin : g_bad_ncs
         $error("xbus_cyc_ctrl: NCS must be 6..8");
      end
      if (WSW < 1 || WSW > 8) begin : g_bad_wsw
         $error("xbus_cyc_ctrl: WSW must be 1..8");
      end
      if (CW < AW || CW < MODE_DLY_LSB + WSW || CW < CTRL_EN_BIT + 1) begin : g_bad_cw
         $error("xbus_cyc_ctrl: CW too narrow for register fields");
      end
   endgenerate

   logic [AW-1:0]  win_base  [NCS];
   logic [AW-1:0]  win_limit [NCS];
   logic [WSW-1:0] win_wait  [NCS];
   logic [NCS-1:0] win_self;
   logic [NCS-1:0] win_en;
   logic           ack_pol;
   logic           strb_mode;
   logic [WSW-1:0] strb_dly;
   logic           gp_mode;
   logic           gp_val;
   logic           gp_oe;
   logic           dec_hit;
   logic [NCS-1:0] dec_oh;
   logic           ack_raw;
   logic           ack_s;
   logic [NCS-1:0] cs_act_oh;
   logic           strb_on;

   xbus_regs #(.AW(AW), .WSW(WSW), .NCS(NCS), .CW(CW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .win_base  (win_base),
      .win_limit (win_limit),
      .win_wait  (win_wait),
      .win_self  (win_self),
      .win_en    (win_en),
      .ack_pol   (ack_pol),
      .strb_mode (strb_mode),
      .strb_dly  (strb_dly),
      .gp_mode   (gp_mode),
      .gp_val    (gp_val),
      .gp_oe     (gp_oe)
   );

   xbus_decode #(.AW(AW), .NCS(NCS)) u_dec (
      .addr      (req_addr),
      .win_base  (win_base),
      .win_limit (win_limit),
      .win_en    (win_en),
      .hit       (dec_hit),
      .sel_oh    (dec_oh)
   );

   assign ack_raw = ack_pol ? xb_ack : !xb_ack;

   xbus_ack_sync #(.STAGES(ACK_SYNC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ack_raw),
      .q     (ack_s)
   );

   xbus_seq #(.AW(AW), .DW(DW), .WSW(WSW), .NCS(NCS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .req_we    (req_we),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .ready     (ready),
      .rsp_rdata (rsp_rdata),
      .dec_hit   (dec_hit),
      .dec_oh    (dec_oh),
      .win_wait  (win_wait),
      .win_self  (win_self),
      .strb_dly  (strb_dly),
      .ack_s     (ack_s),
      .xb_rdata  (xb_rdata),
      .cs_act_oh (cs_act_oh),
      .strb_on   (strb_on),
      .xb_addr   (xb_addr),
      .xb_wdata  (xb_wdata),
      .xb_rd_n   (xb_rd_n),
      .xb_wr_n   (xb_wr_n)
   );

   // pin muxing: plain selects, strobe variant on pin 5, GP variant on pin 4
   generate
      for (genvar i = 0; i < NCS; i++) begin : g_pin
         if (i == CS_STRB) begin : g_strb
            assign xb_cs_n[i] = strb_mode ? !strb_on : !cs_act_oh[i];
         end else if (i == CS_GPIO) begin : g_gp
            assign xb_cs_n[i] = gp_mode ? gp_val : !cs_act_oh[i];
         end else begin : g_plain
            assign xb_cs_n[i] = !cs_act_oh[i];
         end
      end
   endgenerate

   assign xb_gp_oe = gp_mode ? gp_oe : 1'b1;

endmodule

// File: rtl/xbus_chk.sv
module xbus_chk #(
   parameter int NCS = 6,
   parameter int DW  = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           ready,
   input logic [DW-1:0]  rsp_rdata,
   input logic [NCS-1:0] cs_act_oh,
   input logic           strb_mode,
   input logic           strb_pin,
   input logic           rd_n,
   input logic           wr_n
);

   // R7
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);

   // R8
   idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> (cs_act_oh == '0));

   // R8
   one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_act_oh));

   // R6
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && cs_act_oh == '0) |-> (rsp_rdata == '0));

   // R12
   rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> wr_n);

   // R12
   rw_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |-> (cs_act_oh != '0));

   // R9
   strb_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_mode && cs_act_oh == '0) |-> strb_pin);

endmodule

bind xbus_cyc_ctrl xbus_chk #(.NCS(NCS), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ready     (ready),
   .rsp_rdata (rsp_rdata),
   .cs_act_oh (cs_act_oh),
   .strb_mode (strb_mode),
   .strb_pin  (xb_cs_n[xbus_pkg::CS_STRB]),
   .rd_n      (xb_rd_n),
   .wr_n      (xb_wr_n)
);

// File: tb/sim_xbus_cyc_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_cyc_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        req_we = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        ready;
   logic [15:0] rsp_rdata;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [15:0] xb_addr;
   logic [15:0] xb_wdata;
   logic [15:0] xb_rdata;
   logic        xb_rd_n;
   logic        xb_wr_n;
   logic [5:0]  xb_cs_n;
   logic        xb_ack;
   logic        xb_gp_oe;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // bench-side register model
   int m_base [6];
   int m_lim  [6];
   int m_w    [6];
   bit m_self [6];
   bit m_en   [6];
   bit m_pol = 0, m_strb = 0, m_gp = 0, m_gpv = 0, m_gpoe = 0;
   int m_dly = 0;
   bit ack_on = 0;

   always #2.5 clk = ~clk;

   assign xb_ack   = m_pol ? ack_on : !ack_on;
   assign xb_rdata = xb_addr ^ 16'hA5A5;

   xbus_cyc_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .ready(ready), .rsp_rdata(rsp_rdata), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .xb_addr(xb_addr), .xb_wdata(xb_wdata),
      .xb_rdata(xb_rdata), .xb_rd_n(xb_rd_n), .xb_wr_n(xb_wr_n), .xb_cs_n(xb_cs_n),
      .xb_ack(xb_ack), .xb_gp_oe(xb_gp_oe)
   );

   task automatic chk(bit ok, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", what, act, exp, $time);
      end
   endtask

   task automatic cfg_wr(logic [4:0] a, logic [31:0] d);
      int i;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      i = int'(a[2:0]);
      case (a[4:3])
         2'd0: m_base[i] = int'(d[15:0]);
         2'd1: m_lim[i]  = int'(d[15:0]);
         2'd2: begin m_w[i] = int'(d[3:0]); m_self[i] = d[8]; m_en[i] = d[9]; end
         default: case (a[2:0])
            3'd0: begin m_pol = d[0]; m_strb = d[1]; m_dly = int'(d[11:8]); end
            3'd1: m_gp = d[0];
            3'd2: begin m_gpv = d[0]; m_gpoe = d[1]; end
            default: ;
         endcase
      endcase
   endtask

   function automatic int exp_win(int a);
      for (int i = 0; i < 6; i++)
         if (m_en[i] && a >= m_base[i] && a <= m_lim[i]) return i;
      return -1;
   endfunction

   function automatic int exp_lat(int w, int ack_at);
      int t;
      if (w < 0) return 0;
      if (m_self[w]) return m_w[w];
      t = ack_at + 2;
      return (t > m_w[w]) ? t : m_w[w];
   endfunction

   function automatic logic [5:0] exp_pins(int w, int k);
      logic [5:0] p;
      int d;
      p = '1;
      if (w >= 0) p[w] = 1'b0;
      if (m_strb) begin
         d = 0;
         if (w >= 0) d = (m_dly < m_w[w]) ? m_dly : m_w[w];
         p[5] = !(w >= 0 && k >= d);
      end
      if (m_gp) p[4] = m_gpv;
      return p;
   endfunction

   // one request; starts and ends at a falling edge
   task automatic run_cyc(int a, bit we, int wd, int ack_at, int drop_at, bit keep);
      int w, lat, k, er;
      bit got;
      logic [5:0] ep;
      w = exp_win(a);
      lat = exp_lat(w, ack_at);
      req = 1'b1; req_we = we; req_addr = 16'(a); req_wdata = 16'(wd);
      @(posedge clk);
      k = 0; got = 0;
      while (!got && k < 64) begin
         @(negedge clk);
         ep = exp_pins(w, k);
         chk(xb_cs_n == ep, "R1/R9/R10 cs_n pins", int'(xb_cs_n), int'(ep));
         chk(xb_gp_oe == (m_gp ? m_gpoe : 1'b1), "R10 gp_oe", int'(xb_gp_oe), int'(m_gp ? m_gpoe : 1'b1));
         chk({xb_rd_n, xb_wr_n} == {!(w >= 0 && !we), !(w >= 0 && we)},
             "R12 rd_n/wr_n", int'({xb_rd_n, xb_wr_n}), int'({!(w >= 0 && !we), !(w >= 0 && we)}));
         if (w >= 0)
            chk(xb_addr == 16'(a) && (!we || xb_wdata == 16'(wd)), "R12 addr/wdata",
                int'(xb_addr), a);
         if (ready) begin
            got = 1;
            // R2 R3 R4 R5 R6: completion clock
            chk(k == lat, "R2/R3/R4/R5/R6 completion clock", k, lat);
            er = (w >= 0 && !we) ? ((a ^ 'hA5A5) & 'hFFFF) : 0;
            chk(int'(rsp_rdata) == er, "R6/R7 read data", int'(rsp_rdata), er);
            req = 1'b0;
            if (!keep) ack_on = 1'b0;
         end else begin
            if (k == drop_at) ack_on = 1'b0;
            if (k == ack_at)  ack_on = 1'b1;
            k++;
         end
      end
      if (!got) chk(1'b0, "R2/R3 ready never came", k, lat);
      @(negedge clk);
      // R8: idle clock after completion, R7: single pulse
      chk(!ready && xb_cs_n == exp_pins(-1, 0), "R7/R8 gap clock", int'({ready, xb_cs_n}),
          int'({1'b0, exp_pins(-1, 0)}));
   endtask

   initial begin
      int r, a, w;
      void'($urandom(32'd7781));
      for (int i = 0; i < 6; i++) begin
         m_base[i] = 0; m_lim[i] = 0; m_w[i] = 0; m_self[i] = 0; m_en[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(xb_cs_n == 6'h3F && !ready && xb_gp_oe && xb_rd_n && xb_wr_n, "R11 reset pins",
          int'({ready, xb_gp_oe, xb_cs_n}), int'({1'b0, 1'b1, 6'h3F}));
      // R11 windows disabled after reset: any address misses (R6)
      run_cyc('h1234, 0, 0, -1, -1, 0);

      // windows: base, limit, wait, self
      cfg_wr(5'h00, 'h1000); cfg_wr(5'h08, 'h1FFF); cfg_wr(5'h10, 2 | (1 << 8) | (1 << 9));
      cfg_wr(5'h01, 'h1800); cfg_wr(5'h09, 'h27FF); cfg_wr(5'h11, 3 | (1 << 9));
      cfg_wr(5'h02, 'h3000); cfg_wr(5'h0A, 'h3FFF); cfg_wr(5'h12, 0 | (1 << 8) | (1 << 9));
      cfg_wr(5'h03, 'h4000); cfg_wr(5'h0B, 'h4FFF); cfg_wr(5'h13, 5 | (1 << 9));
      cfg_wr(5'h04, 'h5000); cfg_wr(5'h0C, 'h5FFF); cfg_wr(5'h14, 1 | (1 << 8) | (1 << 9));
      cfg_wr(5'h05, 'h6000); cfg_wr(5'h0D, 'h6FFF); cfg_wr(5'h15, 4 | (1 << 8) | (1 << 9));

      // R1 overlap: lowest index wins, above overlap the higher window
      run_cyc('h1900, 0, 0, 0, -1, 0);
      run_cyc('h2100, 1, 'h5A5A, 0, -1, 0);
      // R2 self-ack ignores an acknowledge raised early
      run_cyc('h3010, 0, 0, 0, -1, 0);
      run_cyc('h6004, 0, 0, 1, -1, 0);
      // R3 acknowledge later than the wait count stretches the cycle
      run_cyc('h4444, 0, 0, 6, -1, 0);
      // R6 unmapped address
      run_cyc('h9000, 0, 0, -1, -1, 0);

      // R5 stale acknowledge: keep it high, next cycle needs a low then a high
      run_cyc('h4100, 0, 0, 0, -1, 1);
      run_cyc('h2200, 0, 0, 4, 3, 0);

      // R4 active-high acknowledge
      cfg_wr(5'h18, 'h1);
      repeat (3) @(negedge clk);
      run_cyc('h4200, 0, 0, 1, -1, 0);
      run_cyc('h2300, 1, 'h1111, 3, -1, 0);
      cfg_wr(5'h18, 'h0);
      repeat (3) @(negedge clk);

      // R9 strobe on pin 5, delay 2, then delay beyond the wait count
      cfg_wr(5'h18, 'h0202);
      run_cyc('h4300, 0, 0, 0, -1, 0);
      run_cyc('h3300, 1, 'h2222, -1, -1, 0);
      run_cyc('h6300, 0, 0, -1, -1, 0);
      cfg_wr(5'h18, 'h0702);
      run_cyc('h4400, 1, 'h3333, 0, -1, 0);
      cfg_wr(5'h18, 'h0);

      // R10 general-purpose pin
      cfg_wr(5'h1A, 'h2); cfg_wr(5'h19, 'h1);
      @(negedge clk);
      chk(xb_cs_n[4] == 1'b0 && xb_gp_oe == 1'b1, "R10 gp idle", int'({xb_gp_oe, xb_cs_n[4]}), 2);
      run_cyc('h5100, 0, 0, -1, -1, 0);
      cfg_wr(5'h1A, 'h1);
      run_cyc('h5200, 1, 'h4444, -1, -1, 0);
      cfg_wr(5'h19, 'h0);

      // random mix
      for (int n = 0; n < 80; n++) begin
         r = int'($urandom_range(0, 6));
         if (r == 6) a = 'h8000 | int'($urandom_range(0, 'hFFF));
         else a = m_base[r] + int'($urandom_range(0, 'hFFF));
         w = int'($urandom_range(0, 4));
         run_cyc(a, bit'($urandom_range(0, 1)), int'($urandom_range(0, 'hFFFF)), w, -1, 0);
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired act=0 exp=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule